// File: doc/BRIEF.md
# Scan-List Acquisition Sequencer

This block paces a series of analog-to-digital conversions. Its pace and channel order come from a list of conversion entries that the host writes. Each entry names the channel type, bank, channel number, gain, polarity and dither setting for one conversion. Two flag bits in the entry shape the run. A ghost flag makes the conversion run but discards its result. A last flag closes the current scan. The list may hold several last flags, so successive scans walk through different segments of the same list. This makes multirate and interval scanning possible from a single list.

Three down-counters run on a timebase tick enable:

- The scan-interval counter spaces the starts of scans.
- The sample-interval counter spaces conversions inside a scan. It has a first-period count and a later-period count.
- The scan counter sets how many scans run before the acquisition stops, or it reloads forever in continuous mode.

For each conversion the block emits a one-cycle convert strobe together with the entry's fields. The converter returns a result on `adcValid`/`adcData`, and the block pushes every result that is not a ghost into a show-ahead sample FIFO.

The host uses a write-only register bus: `regWr`, `regAddr` and `regWData`. It reads the FIFO with `regRd`.

| Address | Register | Bits used |
|---|---|---|
| 0 | Append a list entry | `regWData[15:0]` |
| 1 | List clear | bit0 |
| 2 | Configuration window | bit0 opens, bit1 closes |
| 3 | Scan-count load value | full width |
| 4 | Scan-interval load value | full width |
| 5 | Sample first-period load value | full width |
| 6 | Sample later-period load value | full width |
| 7 | Mode | bit0 continuous, bit1 reload |
| 8 | Load command | bit0 scan count, bit1 scan interval, bit2 both sample values |
| 9 | Arm | bits 3:0 |
| 10 | Start | bit0 |
| 11 | Disarm | bit0 |

Every count is written as the wanted number of ticks or scans minus one.

Top module: `acq_scan_seq`

## Requirements
- R1: A write to address 0 stores `regWData[15:0]` as a list entry at the write position, and the write position then advances. The entry fields are: bits 15:13 channel type, 12:11 bank, 10:7 channel, 6 last, 5 ghost, 4 dither, 3 polarity, 2:0 gain. A write of bit0 to address 1 empties the list and returns the write position to the first location.
- R2: Each conversion raises `convStrobe` for one cycle with the current entry's fields on the conv outputs. It then advances the list pointer, which wraps to the first entry after the last written entry.
- R3: The result that follows a ghost entry's strobe is not written to the FIFO. Results of other entries are written.
- R4: Inside a scan, the first conversion comes first-period+1 ticks after the scan starts. When reload mode (address 7 bit1) is set, each later conversion follows the previous one by later-period+1 ticks. When reload mode is clear, the first-period count is used for every gap.
- R5: Scans start every scan-interval+1 ticks, counted from the start command.
- R6: An entry with the last flag ends the current scan. The next scan resumes at the following list entry, so a list with several last flags yields scans of different lengths.
- R7: When continuous mode is off, the run stops after scan-count+1 scans. `running` falls, and no further strobes occur.
- R8: When continuous mode (address 7 bit0) is on, the scan counter reloads at zero. The run stops only on a disarm (address 11 bit0).
- R9: A start (address 10 bit0) takes effect only when all four arm bits (address 9, bits 3:0) are set and the list is not empty. Otherwise it is ignored.
- R10: Load values reach the counters only through a load command (address 8) that is written while the configuration window is open. A load command written with the window closed has no effect.
- R11: `fifoNotEmpty` is high while results are held. `fifoData` shows the oldest result, and `regRd` removes it. Results leave the FIFO in arrival order.
- R12: `fifoOverflow` sets when a result that is not a ghost arrives while the FIFO is full. That result is dropped, and the flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWData | input | CNT_W | Register write data |
| regRd | input | 1 | Remove the oldest FIFO result |
| tbTick | input | 1 | Timebase tick enable for all counters |
| adcValid | input | 1 | Converter result valid |
| adcData | input | DATA_W | Converter result |
| convStrobe | output | 1 | Convert request, one cycle |
| convType | output | 3 | Channel type of the current conversion |
| convBank | output | 2 | Bank of the current conversion |
| convChan | output | 4 | Channel number of the current conversion |
| convGain | output | 3 | Gain code of the current conversion |
| convPolarity | output | 1 | Polarity of the current conversion |
| convDither | output | 1 | Dither enable of the current conversion |
| running | output | 1 | Acquisition in progress |
| fifoData | output | DATA_W | Oldest FIFO result |
| fifoNotEmpty | output | 1 | FIFO holds at least one result |
| fifoOverflow | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach is the overflow. It needs more results than the FIFO holds, from a run that never stops by itself. The bench gets there with a continuous run over a one-entry list and a short scan interval, and it leaves the FIFO unread. It then disarms, checks that the strobes have ceased, and drains the FIFO to show that exactly its depth was kept and that the flag survives the drain. The interplay of ghost entries, several last flags and pointer wrap is reached with short lists whose scan count exceeds the number of segments in the list. In those runs the bench compares the channel order, the spacing between strobes and the results left in the FIFO.

// File: rtl/acq_pkg.sv
package acq_pkg;

  // one scan-list entry; field order is the host-visible layout
  typedef struct packed {
    logic [2:0] chanType;
    logic [1:0] bank;
    logic [3:0] chan;
    logic       last;
    logic       ghost;
    logic       dither;
    logic       polarity;
    logic [2:0] gain;
  } listEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic listWr;
    logic listClr;
    logic seqRestart;
    logic doConv;
  } seqCmd_t;

  localparam logic [3:0] REG_LIST_WR     = 4'd0;
  localparam logic [3:0] REG_LIST_CLR    = 4'd1;
  localparam logic [3:0] REG_CFG         = 4'd2;
  localparam logic [3:0] REG_SCAN_CNT    = 4'd3;
  localparam logic [3:0] REG_SCAN_INT    = 4'd4;
  localparam logic [3:0] REG_SAMP_FIRST  = 4'd5;
  localparam logic [3:0] REG_SAMP_NEXT   = 4'd6;
  localparam logic [3:0] REG_MODE        = 4'd7;
  localparam logic [3:0] REG_LOAD_CMD    = 4'd8;
  localparam logic [3:0] REG_ARM         = 4'd9;
  localparam logic [3:0] REG_START       = 4'd10;
  localparam logic [3:0] REG_DISARM      = 4'd11;

endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [3:0]       regAddr,
  input  logic [CNT_W-1:0] regWData,
  input  logic             tbTick,
  input  logic             listEmpty,
  input  logic             entryLast,
  output seqCmd_t          cmd,
  output logic             running
);

  localparam int ARM_BITS = 4;

  logic             cfgOpen;
  logic [CNT_W-1:0] scStage, siStage, sampAStage, sampBStage;
  logic [CNT_W-1:0] scLoad, siLoad, sampALoad, sampBLoad;
  logic             contMode, reloadMode;
  logic [ARM_BITS-1:0] armBits;
  logic             inScan;
  logic [CNT_W-1:0] sampCnt, scanIntCnt, scanCnt;

  logic wrCfg, wrLoad, wrArm, wrDisarm, wrMode;
  logic startReq, tickAct, scanTrig, convNow, scanDone, finalScan, disarmReq;

  always_comb begin
    wrCfg     = regWr && (regAddr == REG_CFG);
    wrLoad    = regWr && (regAddr == REG_LOAD_CMD) && cfgOpen;
    wrArm     = regWr && (regAddr == REG_ARM);
    wrDisarm  = regWr && (regAddr == REG_DISARM);
    wrMode    = regWr && (regAddr == REG_MODE);
    disarmReq = wrDisarm && regWData[0];
    startReq  = regWr && (regAddr == REG_START) && regWData[0] &&
                (&armBits) && !listEmpty && !running;
    tickAct   = running && tbTick;
    scanTrig  = tickAct && (scanIntCnt == '0);
    convNow   = tickAct && inScan && (sampCnt == '0);
    scanDone  = convNow && entryLast;
    finalScan = scanDone && (scanCnt == '0) && !contMode;

    cmd.listWr     = regWr && (regAddr == REG_LIST_WR);
    cmd.listClr    = regWr && (regAddr == REG_LIST_CLR) && regWData[0];
    cmd.seqRestart = startReq;
    cmd.doConv     = convNow;
  end

  // configuration window, staging and active load values
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgOpen    <= 1'b0;
      scStage    <= '0;
      siStage    <= '0;
      sampAStage <= '0;
      sampBStage <= '0;
      scLoad     <= '0;
      siLoad     <= '0;
      sampALoad  <= '0;
      sampBLoad  <= '0;
      contMode   <= 1'b0;
      reloadMode <= 1'b0;
    end else begin
      if (wrCfg) begin
        if (regWData[1])      cfgOpen <= 1'b0;
        else if (regWData[0]) cfgOpen <= 1'b1;
      end
      if (regWr && regAddr == REG_SCAN_CNT)   scStage    <= regWData;
      if (regWr && regAddr == REG_SCAN_INT)   siStage    <= regWData;
      if (regWr && regAddr == REG_SAMP_FIRST) sampAStage <= regWData;
      if (regWr && regAddr == REG_SAMP_NEXT)  sampBStage <= regWData;
      if (wrMode) begin
        contMode   <= regWData[0];
        reloadMode <= regWData[1];
      end
      if (wrLoad) begin
        if (regWData[0]) scLoad <= scStage;
        if (regWData[1]) siLoad <= siStage;
        if (regWData[2]) begin
          sampALoad <= sampAStage;
          sampBLoad <= sampBStage;
        end
      end
    end
  end

  // arming and run state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armBits <= '0;
      running <= 1'b0;
      inScan  <= 1'b0;
    end else begin
      if (disarmReq || finalScan) armBits <= '0;
      else if (wrArm)             armBits <= armBits | regWData[ARM_BITS-1:0];

      if (startReq)                    running <= 1'b1;
      else if (disarmReq || finalScan) running <= 1'b0;

      if (startReq) inScan <= 1'b1;
      else if (tickAct) begin
        if (scanDone)              inScan <= 1'b0;
        else if (!inScan && scanTrig) inScan <= 1'b1;
      end
    end
  end

  // interval and scan counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampCnt    <= '0;
      scanIntCnt <= '0;
      scanCnt    <= '0;
    end else if (startReq) begin
      sampCnt    <= sampALoad;
      scanIntCnt <= siLoad;
      scanCnt    <= scLoad;
    end else if (tickAct) begin
      scanIntCnt <= scanTrig ? siLoad : scanIntCnt - 1'b1;
      if (inScan) begin
        if (sampCnt == '0) sampCnt <= reloadMode ? sampBLoad : sampALoad;
        else               sampCnt <= sampCnt - 1'b1;
      end else if (scanTrig) begin
        sampCnt <= sampALoad;
      end
      if (scanDone) scanCnt <= (scanCnt == '0) ? scLoad : scanCnt - 1'b1;
    end
  end

endmodule

// File: rtl/acq_data.sv
module acq_data
  import acq_pkg::*;
#(
  parameter int LIST_DEPTH = 512,
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 16,
  localparam int LIST_AW   = $clog2(LIST_DEPTH),
  localparam int FIFO_AW   = $clog2(FIFO_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  input  listEntry_t        listWData,
  input  logic              adcValid,
  input  logic [DATA_W-1:0] adcData,
  input  logic              fifoRd,
  output logic              listEmpty,
  output logic              entryLast,
  output logic              convStrobe,
  output listEntry_t        convEntry,
  output logic              pendGhost,
  output logic [DATA_W-1:0] fifoData,
  output logic              fifoNotEmpty,
  output logic              fifoOverflow,
  output logic [FIFO_AW:0]  fifoLevel
);

  // scan list
  listEntry_t          listMem [LIST_DEPTH];
  logic [LIST_AW:0]    listCount;
  logic [LIST_AW-1:0]  rdPtr;
  listEntry_t          curEntry;
  logic                listFull, wrapNext;

  always_comb begin
    curEntry  = listMem[rdPtr];
    listEmpty = (listCount == '0);
    listFull  = (listCount == (LIST_AW+1)'(LIST_DEPTH));
    entryLast = curEntry.last;
    wrapNext  = (({1'b0, rdPtr} + 1'b1) == listCount);
  end

  always_ff @(posedge clk) begin
    if (cmd.listWr && !listFull && !cmd.listClr)
      listMem[listCount[LIST_AW-1:0]] <= listWData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      listCount <= '0;
      rdPtr     <= '0;
    end else if (cmd.listClr) begin
      listCount <= '0;
      rdPtr     <= '0;
    end else begin
      if (cmd.listWr && !listFull) listCount <= listCount + 1'b1;
      if (cmd.seqRestart)          rdPtr <= '0;
      else if (cmd.doConv)         rdPtr <= wrapNext ? '0 : rdPtr + 1'b1;
    end
  end

  // convert outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convStrobe <= 1'b0;
      convEntry  <= '0;
      pendGhost  <= 1'b0;
    end else begin
      convStrobe <= cmd.doConv;
      if (cmd.doConv) begin
        convEntry <= curEntry;
        pendGhost <= curEntry.ghost;
      end
    end
  end

  // sample FIFO
  logic [DATA_W-1:0]  fifoMem [FIFO_DEPTH];
  logic [FIFO_AW-1:0] fWrPtr, fRdPtr;
  logic               pushReq, fifoFull, doPush, doPop;

  always_comb begin
    pushReq      = adcValid && !pendGhost;
    fifoFull     = (fifoLevel == (FIFO_AW+1)'(FIFO_DEPTH));
    doPush       = pushReq && !fifoFull;
    doPop        = fifoRd && (fifoLevel != '0);
    fifoNotEmpty = (fifoLevel != '0);
    fifoData     = fifoMem[fRdPtr];
  end

  always_ff @(posedge clk) begin
    if (doPush) fifoMem[fWrPtr] <= adcData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fWrPtr       <= '0;
      fRdPtr       <= '0;
      fifoLevel    <= '0;
      fifoOverflow <= 1'b0;
    end else begin
      if (doPush) fWrPtr <= fWrPtr + 1'b1;
      if (doPop)  fRdPtr <= fRdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fifoLevel <= fifoLevel + 1'b1;
        2'b01:   fifoLevel <= fifoLevel - 1'b1;
        default: fifoLevel <= fifoLevel;
      endcase
      if (pushReq && fifoFull) fifoOverflow <= 1'b1;
    end
  end

endmodule

// File: rtl/acq_scan_seq.sv
module acq_scan_seq
  import acq_pkg::*;
#(
  parameter int LIST_DEPTH = 512,
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [3:0]        regAddr,
  input  logic [CNT_W-1:0]  regWData,
  input  logic              regRd,
  input  logic              tbTick,
  input  logic              adcValid,
  input  logic [DATA_W-1:0] adcData,
  output logic              convStrobe,
  output logic [2:0]        convType,
  output logic [1:0]        convBank,
  output logic [3:0]        convChan,
  output logic [2:0]        convGain,
  output logic              convPolarity,
  output logic              convDither,
  output logic              running,
  output logic [DATA_W-1:0] fifoData,
  output logic              fifoNotEmpty,
  output logic              fifoOverflow
);

  localparam int FIFO_AW = $clog2(FIFO_DEPTH);

  seqCmd_t           seqCmd;
  listEntry_t        convEntry;
  logic              listEmpty, entryLast, pendGhost;
  logic [FIFO_AW:0]  fifoLevel;

  acq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWData  (regWData),
    .tbTick    (tbTick),
    .listEmpty (listEmpty),
    .entryLast (entryLast),
    .cmd       (seqCmd),
    .running   (running)
  );

  acq_data #(
    .LIST_DEPTH (LIST_DEPTH),
    .FIFO_DEPTH (FIFO_DEPTH),
    .DATA_W     (DATA_W)
  ) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (seqCmd),
    .listWData    (listEntry_t'(regWData[15:0])),
    .adcValid     (adcValid),
    .adcData      (adcData),
    .fifoRd       (regRd),
    .listEmpty    (listEmpty),
    .entryLast    (entryLast),
    .convStrobe   (convStrobe),
    .convEntry    (convEntry),
    .pendGhost    (pendGhost),
    .fifoData     (fifoData),
    .fifoNotEmpty (fifoNotEmpty),
    .fifoOverflow (fifoOverflow),
    .fifoLevel    (fifoLevel)
  );

  assign convType     = convEntry.chanType;
  assign convBank     = convEntry.bank;
  assign convChan     = convEntry.chan;
  assign convGain     = convEntry.gain;
  assign convPolarity = convEntry.polarity;
  assign convDither   = convEntry.dither;

endmodule

// File: rtl/acq_scan_seq_chk.sv
module acq_scan_seq_chk
  import acq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic [3:0]       regAddr,
  input logic             regWData0,
  input logic             regRd,
  input logic             adcValid,
  input logic             pendGhost,
  input logic             convStrobe,
  input logic             running,
  input logic             fifoNotEmpty,
  input logic             fifoOverflow,
  input logic [LVL_W-1:0] fifoLevel
);

  AST_STROBE_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    convStrobe |-> $past(running)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fifoOverflow |=> fifoOverflow); // R12

  AST_PUSH_SEEN: assert property (@(posedge clk) disable iff (!rstN)
    (adcValid && !pendGhost) |=> fifoNotEmpty); // R11

  AST_GHOST_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (adcValid && pendGhost && !regRd) |=> (fifoLevel == $past(fifoLevel))); // R3

  AST_START_BY_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(regWr && regAddr == REG_START && regWData0)); // R9

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel <= LVL_W'(FIFO_DEPTH)); // R12

endmodule

bind acq_scan_seq acq_scan_seq_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .regWr        (regWr),
  .regAddr      (regAddr),
  .regWData0    (regWData[0]),
  .regRd        (regRd),
  .adcValid     (adcValid),
  .pendGhost    (pendGhost),
  .convStrobe   (convStrobe),
  .running      (running),
  .fifoNotEmpty (fifoNotEmpty),
  .fifoOverflow (fifoOverflow),
  .fifoLevel    (fifoLevel)
);

// File: tb/tb_acq_scan_seq.sv
`timescale 1ns/1ps
module tb_acq_scan_seq;
  import acq_pkg::*;

  localparam int FIFO_DEPTH = 16;
  localparam int CNT_W      = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [3:0] regAddr = '0;
  logic [CNT_W-1:0] regWData = '0;
  logic regRd = 1'b0;
  logic tbTick = 1'b1;
  logic adcValid = 1'b0;
  logic [15:0] adcData = '0;
  logic convStrobe, convPolarity, convDither, running, fifoNotEmpty, fifoOverflow;
  logic [2:0] convType, convGain;
  logic [1:0] convBank;
  logic [3:0] convChan;
  logic [15:0] fifoData;

  always #4 clk = ~clk;

  acq_scan_seq #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWData(regWData),
    .regRd(regRd), .tbTick(tbTick), .adcValid(adcValid), .adcData(adcData),
    .convStrobe(convStrobe), .convType(convType), .convBank(convBank),
    .convChan(convChan), .convGain(convGain), .convPolarity(convPolarity),
    .convDither(convDither), .running(running), .fifoData(fifoData),
    .fifoNotEmpty(fifoNotEmpty), .fifoOverflow(fifoOverflow)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int strobeCnt = 0;
  int stamp [128];
  int chanLog [128];
  int gainLog [128];
  int polLog [128];
  int typeLog [128];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkEntry(input int typ, input int bank, input int chan,
                                          input int last, input int ghost, input int pol,
                                          input int gain);
    return {3'(typ), 2'(bank), 4'(chan), 1'(last), 1'(ghost), 1'b0, 1'(pol), 3'(gain)};
  endfunction

  function automatic logic [15:0] expData(input int bank, input int chan, input int idx);
    return {4'hA, 2'(bank), 4'(chan), 6'(idx)};
  endfunction

  // monitor and converter model: answers one cycle after each strobe
  initial begin
    logic pend = 1'b0;
    logic [15:0] pendData = '0;
    forever begin
      @(negedge clk);
      cyc++;
      adcValid = pend;
      adcData  = pendData;
      pend = 1'b0;
      if (convStrobe) begin
        if (strobeCnt < 128) begin
          stamp[strobeCnt]   = cyc;
          chanLog[strobeCnt] = int'(convChan);
          gainLog[strobeCnt] = int'(convGain);
          polLog[strobeCnt]  = int'(convPolarity);
          typeLog[strobeCnt] = int'(convType);
        end
        pend = 1'b1;
        pendData = expData(int'(convBank), int'(convChan), strobeCnt);
        strobeCnt++;
      end
    end
  end

  task automatic busWrite(input logic [3:0] addr, input int data);
    @(negedge clk);
    regWr = 1'b1; regAddr = addr; regWData = CNT_W'(data);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic configure(input int sc, input int si, input int a, input int b, input int mode);
    busWrite(REG_CFG, 1);
    busWrite(REG_SCAN_CNT, sc);
    busWrite(REG_SCAN_INT, si);
    busWrite(REG_SAMP_FIRST, a);
    busWrite(REG_SAMP_NEXT, b);
    busWrite(REG_LOAD_CMD, 7);
    busWrite(REG_MODE, mode);
    busWrite(REG_CFG, 2);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000 && running; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic popFifo(output logic [15:0] d);
    @(negedge clk);
    d = fifoData;
    regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic t_reset();
    check(fifoNotEmpty == 1'b0, "R11 reset empty", int'(fifoNotEmpty), 0);
    check(fifoOverflow == 1'b0, "R12 reset overflow", int'(fifoOverflow), 0);
    check(running == 1'b0, "R7 reset idle", int'(running), 0);
    check(convStrobe == 1'b0, "R2 reset strobe", int'(convStrobe), 0);
  endtask

  // ghost entry, reload mode, two scans over a 3-entry list
  task automatic t_ghostScan();
    int base;
    logic [15:0] d;
    busWrite(REG_LIST_CLR, 1);
    busWrite(REG_LIST_WR, mkEntry(1, 0, 5, 0, 0, 1, 2));
    busWrite(REG_LIST_WR, mkEntry(2, 0, 4, 0, 1, 0, 1));
    busWrite(REG_LIST_WR, mkEntry(3, 1, 1, 1, 0, 0, 3));
    configure(1, 40, 3, 5, 2);
    base = strobeCnt;
    busWrite(REG_ARM, 15);
    busWrite(REG_START, 1);
    waitIdle();
    check(strobeCnt - base == 6, "R7 two scans of three", strobeCnt - base, 6);
    check(running == 1'b0, "R7 stopped", int'(running), 0);
    check(chanLog[base] == 5 && chanLog[base+1] == 4 && chanLog[base+2] == 1,
          "R2 channel order", chanLog[base+1], 4);
    check(chanLog[base+3] == 5, "R2 pointer wraps", chanLog[base+3], 5);
    check(gainLog[base] == 2 && polLog[base] == 1 && typeLog[base] == 1,
          "R1 entry fields", gainLog[base], 2);
    check(stamp[base+1] - stamp[base] == 6, "R4 later period", stamp[base+1] - stamp[base], 6);
    check(stamp[base+2] - stamp[base+1] == 6, "R4 later period 2", stamp[base+2] - stamp[base+1], 6);
    check(stamp[base+3] - stamp[base] == 41, "R5 scan spacing", stamp[base+3] - stamp[base], 41);
    popFifo(d); check(d == expData(0, 5, base),   "R11 first result", int'(d), int'(expData(0, 5, base)));
    popFifo(d); check(d == expData(1, 1, base+2), "R3 ghost skipped", int'(d), int'(expData(1, 1, base+2)));
    popFifo(d); check(d == expData(0, 5, base+3), "R11 order", int'(d), int'(expData(0, 5, base+3)));
    popFifo(d); check(d == expData(1, 1, base+5), "R3 ghost skipped 2", int'(d), int'(expData(1, 1, base+5)));
    @(negedge clk);
    check(fifoNotEmpty == 1'b0, "R3 only four kept", int'(fifoNotEmpty), 0);
  endtask

  // several last flags, no reload mode
  task automatic t_multiLast();
    int base;
    logic [15:0] d;
    busWrite(REG_LIST_CLR, 1);
    busWrite(REG_LIST_WR, mkEntry(0, 0, 2, 1, 0, 0, 0));
    busWrite(REG_LIST_WR, mkEntry(0, 0, 7, 0, 0, 0, 0));
    busWrite(REG_LIST_WR, mkEntry(0, 0, 8, 1, 0, 0, 0));
    busWrite(REG_LIST_WR, mkEntry(0, 0, 3, 1, 0, 0, 0));
    configure(2, 30, 4, 9, 0);
    base = strobeCnt;
    busWrite(REG_ARM, 15);
    busWrite(REG_START, 1);
    waitIdle();
    check(strobeCnt - base == 4, "R6 segment scans", strobeCnt - base, 4);
    check(chanLog[base] == 2 && chanLog[base+1] == 7 && chanLog[base+2] == 8 && chanLog[base+3] == 3,
          "R6 segment order", chanLog[base+3], 3);
    check(stamp[base+2] - stamp[base+1] == 5, "R4 first period reused", stamp[base+2] - stamp[base+1], 5);
    check(stamp[base+1] - stamp[base] == 31, "R5 scan spacing", stamp[base+1] - stamp[base], 31);
    check(stamp[base+3] - stamp[base+1] == 31, "R5 scan spacing 2", stamp[base+3] - stamp[base+1], 31);
    for (int k = 0; k < 4; k++) popFifo(d);
    @(negedge clk);
    check(fifoNotEmpty == 1'b0, "R11 drained", int'(fifoNotEmpty), 0);
  endtask

  // start ignored without full arming or with an empty list
  task automatic t_armGate();
    int base = strobeCnt;
    busWrite(REG_ARM, 7);
    busWrite(REG_START, 1);
    repeat (30) @(negedge clk);
    check(running == 1'b0, "R9 partial arm", int'(running), 0);
    check(strobeCnt == base, "R9 no strobes", strobeCnt - base, 0);
    busWrite(REG_LIST_CLR, 1);
    busWrite(REG_ARM, 15);
    busWrite(REG_START, 1);
    repeat (30) @(negedge clk);
    check(running == 1'b0, "R9 empty list", int'(running), 0);
    check(strobeCnt == base, "R1 cleared list idle", strobeCnt - base, 0);
  endtask

  // load command outside the configuration window; list restarts at first location
  task automatic t_loadGate();
    int base;
    logic [15:0] d;
    busWrite(REG_LIST_WR, mkEntry(0, 0, 9, 1, 0, 0, 0));
    configure(0, 20, 2, 2, 0);
    busWrite(REG_SCAN_CNT, 3);
    busWrite(REG_LOAD_CMD, 1);
    base = strobeCnt;
    busWrite(REG_ARM, 15);
    busWrite(REG_START, 1);
    waitIdle();
    check(strobeCnt - base == 1, "R10 closed-window load ignored", strobeCnt - base, 1);
    check(chanLog[base] == 9, "R1 write position reset", chanLog[base], 9);
    popFifo(d);
    check(d == expData(0, 9, base), "R11 single result", int'(d), int'(expData(0, 9, base)));
  endtask

  // continuous run, overflow, disarm
  task automatic t_continuous();
    int base, held, cnt;
    logic [15:0] d, first;
    busWrite(REG_LIST_CLR, 1);
    busWrite(REG_LIST_WR, mkEntry(0, 2, 6, 1, 0, 0, 0));
    configure(0, 8, 2, 2, 1);
    base = strobeCnt;
    busWrite(REG_ARM, 15);
    busWrite(REG_START, 1);
    repeat (200) @(negedge clk);
    check(running == 1'b1, "R8 still running", int'(running), 1);
    check(strobeCnt - base >= 20, "R8 reloads", strobeCnt - base, 20);
    check(fifoOverflow == 1'b1, "R12 overflow set", int'(fifoOverflow), 1);
    busWrite(REG_DISARM, 1);
    repeat (4) @(negedge clk);
    check(running == 1'b0, "R8 disarm stops", int'(running), 0);
    held = strobeCnt;
    repeat (40) @(negedge clk);
    check(strobeCnt == held, "R8 no strobes after disarm", strobeCnt - held, 0);
    popFifo(first);
    check(first == expData(2, 6, base), "R12 oldest kept", int'(first), int'(expData(2, 6, base)));
    cnt = 1;
    for (int k = 0; k < 40 && fifoNotEmpty; k++) begin
      popFifo(d);
      cnt++;
    end
    check(cnt == FIFO_DEPTH, "R12 depth retained", cnt, FIFO_DEPTH);
    check(fifoOverflow == 1'b1, "R12 sticky after drain", int'(fifoOverflow), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_ghostScan();
    t_multiLast();
    t_armGate();
    t_loadGate();
    t_continuous();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule